// File: doc/BRIEF.md
# SDLC Transmit Frame Sequencer

This block is the control sequencer in front of an SDLC serial transmitter. It tells the bit shifter what to send next: an opening flag, data bytes taken from a one-byte transmit holding buffer, the frame check sequence, and a closing flag. It handles the chores around a frame without help from software. These chores are the opening flag, clearing the end-of-message latch and presetting the CRC generator, and releasing RTS on the last bit of the closing flag. A force-mark override holds the line high and discards whatever is in flight.

The sequencer has six states: IDLE, OPEN_FLAG, DATA, CRC, CLOSE_FLAG and FORCED_MARK. The transitions are:
- IDLE→OPEN_FLAG on a start condition.
- OPEN_FLAG→DATA at the end of the flag.
- DATA→DATA at the end of a byte when another byte is buffered.
- DATA→CRC at the end of a byte with an empty buffer, which is an underrun.
- CRC→CLOSE_FLAG at the end of the CRC.
- CLOSE_FLAG→IDLE at the end of the flag.
- From any state to FORCED_MARK while the override is high.
- FORCED_MARK→IDLE once the override is released.

A unit ends on a cycle where `bit_tick` and `sh_last` are both high. The shifter raises `sh_last` while it shifts the last bit of the current unit.

Top module: `sdlc_tx_seq`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the outputs are as follows: sh_cmd is 0, crc_preset is 0, txd_high is 0, rts_pin is 0 and eom_latched is 1.
- R2: sh_cmd encodes the unit to send: 0 for idle, 1 for flag, 2 for data and 3 for CRC. A frame steps flag, data, CRC, flag, idle, and it advances only on a cycle with bit_tick and sh_last both high.
- R3: In IDLE the sequencer moves to OPEN_FLAG one clock after a cycle in which all of these hold: the buffer is full, tx_en is 1, eom_latched is 0, and cfg_auto_flag or cfg_idle_flags is 1. If both cfg_auto_flag and cfg_idle_flags are 0, a buffered byte never starts a frame.
- R4: A buf_wr pulse loads the buffer only if tx_en, cfg_auto_flag or cfg_auto_eom is 1. Otherwise the write is lost.
- R5: When a byte ends and a new byte is buffered, another data byte follows. When a byte ends and the buffer is empty, the CRC follows.
- R6: eom_latched becomes 1 on the clock after the closing flag ends. In IDLE, eom_clr clears it only while it is set. While it is set, no frame starts.
- R7: With cfg_auto_eom set, the latch clears on its own in IDLE when the buffer is full and tx_en is 1.
- R8: crc_preset is high for exactly the one clock in which eom_latched has just fallen from 1 to 0. It is never high at any other time.
- R9: Unless auto-RTS is armed (cfg_auto_rts, cfg_sdlc and cfg_flag_on_urun all 1), rts_pin equals rts_bit one clock later.
- R10: When auto-RTS is armed and rts_bit is 0, rts_pin stays asserted during a frame in which it was already asserted. It drops on the clock edge where the last bit of the closing flag ends. Outside a frame it stays low.
- R11: While cfg_force_mark is 1, on the next clock and regardless of tx_en, the following hold: txd_high is 1, sh_cmd is 0, the buffered byte is discarded and buf_wr is ignored. On release the state returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_auto_flag | input | 1 | Send opening flag automatically |
| cfg_auto_eom | input | 1 | Clear EOM latch and preset CRC automatically |
| cfg_auto_rts | input | 1 | Release RTS at end of closing flag |
| cfg_force_mark | input | 1 | Force line high, abort unit in flight |
| cfg_idle_flags | input | 1 | Line idles with flags (1) or mark (0) |
| cfg_sdlc | input | 1 | SDLC mode selected |
| cfg_flag_on_urun | input | 1 | Flag-on-underrun mode selected |
| tx_en | input | 1 | Transmitter enable |
| rts_bit | input | 1 | Programmed RTS control bit |
| eom_clr | input | 1 | Host command to clear the EOM latch |
| buf_wr | input | 1 | Transmit buffer write strobe |
| bit_tick | input | 1 | One-cycle pulse per transmit clock rising edge |
| sh_last | input | 1 | Shifter is on last bit of current unit |
| sh_cmd | output | 2 | Unit command to the shifter |
| crc_preset | output | 1 | One-cycle CRC generator preset |
| txd_high | output | 1 | Override TxD to high |
| rts_pin | output | 1 | RTS asserted |
| eom_latched | output | 1 | Underrun/EOM latch state |

## Verification
All outputs are registered, so every result is due on the clock edge after the cycle that causes it. This applies to a state change, a latch change, the preset pulse, RTS and the force override. A start takes two edges after a buffer write: one to load the buffer and one to leave IDLE. The bench drives inputs and compares outputs on the falling edge. Its reference model steps on the rising edge from the same inputs, so every comparison falls half a period after the edge that should have produced the value. Longer effects are checked by waiting on the sh_cmd value or by counting data bit ticks. These include data-byte chaining, frames that are blocked from starting, and writes that are lost.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPEN   = 3'd1,
        ST_DATA   = 3'd2,
        ST_CRC    = 3'd3,
        ST_CLOSE  = 3'd4,
        ST_MARK   = 3'd5
    } seq_state_t;

    localparam int CMD_W = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_IDLE = 2'd0,
        CMD_FLAG = 2'd1,
        CMD_DATA = 2'd2,
        CMD_CRC  = 2'd3
    } sh_cmd_t;

    function automatic sh_cmd_t cmd_of(input seq_state_t s);
        sh_cmd_t c;
        unique case (s)
            ST_OPEN, ST_CLOSE: c = CMD_FLAG;
            ST_DATA:           c = CMD_DATA;
            ST_CRC:            c = CMD_CRC;
            default:           c = CMD_IDLE;
        endcase
        return c;
    endfunction

    function automatic logic in_frame(input seq_state_t s);
        return (s == ST_OPEN) || (s == ST_DATA) || (s == ST_CRC) || (s == ST_CLOSE);
    endfunction

endpackage

// File: rtl/sdlc_tx_fsm.sv
module sdlc_tx_fsm
    import sdlc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       force_i,
    input  logic       tx_en_i,
    input  logic       auto_flag_i,
    input  logic       auto_eom_i,
    input  logic       idle_flags_i,
    input  logic       buf_wr_i,
    input  logic       unit_end_i,
    input  logic       eom_latched_i,
    output seq_state_t state_o,
    output logic       buf_full_o
);

    seq_state_t state_q, state_d;
    logic       buf_full_q;
    logic       start, consume, accept;

    assign start   = buf_full_q && tx_en_i && !eom_latched_i && (auto_flag_i || idle_flags_i);
    assign consume = unit_end_i && buf_full_q && ((state_q == ST_OPEN) || (state_q == ST_DATA));
    assign accept  = buf_wr_i && !force_i && (tx_en_i || auto_flag_i || auto_eom_i);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (force_i) begin
            state_d = ST_MARK;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start)      state_d = ST_OPEN;
                ST_OPEN:  if (unit_end_i) state_d = ST_DATA;
                ST_DATA:  if (unit_end_i && !buf_full_q) state_d = ST_CRC;
                ST_CRC:   if (unit_end_i) state_d = ST_CLOSE;
                ST_CLOSE: if (unit_end_i) state_d = ST_IDLE;
                ST_MARK:                  state_d = ST_IDLE;
                default:                  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       buf_full_q <= 1'b0;
        else if (force_i) buf_full_q <= 1'b0;
        else              buf_full_q <= (buf_full_q && !consume) || accept;
    end

    assign state_o    = state_q;
    assign buf_full_o = buf_full_q;

    // R11
    mark_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> (state_q == ST_MARK));

    // R11
    mark_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> !buf_full_q);

    // R6
    no_start_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && eom_latched_i) |=> (state_q != ST_OPEN));

    // R2
    crc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CRC && !force_i) |=> (state_q == ST_CRC || state_q == ST_CLOSE));

endmodule

// File: rtl/sdlc_eom_ctl.sv
module sdlc_eom_ctl
    import sdlc_tx_pkg::*;
#(
    parameter logic LATCH_RESET = 1'b1
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       force_i,
    input  logic       tx_en_i,
    input  logic       auto_eom_i,
    input  logic       clr_cmd_i,
    input  logic       unit_end_i,
    input  logic       buf_full_i,
    input  seq_state_t state_i,
    output logic       latched_o,
    output logic       preset_o
);

    logic latched_q, preset_q;
    logic set_ev, clr_host, clr_auto;
    logic idle_ok;

    assign idle_ok  = (state_i == ST_IDLE) && !force_i && latched_q;
    assign set_ev   = (state_i == ST_CLOSE) && unit_end_i && !force_i;
    assign clr_host = idle_ok && clr_cmd_i;
    assign clr_auto = idle_ok && auto_eom_i && buf_full_i && tx_en_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched_q <= LATCH_RESET;
            preset_q  <= 1'b0;
        end else begin
            preset_q <= clr_host || clr_auto;
            if (set_ev)                    latched_q <= 1'b1;
            else if (clr_host || clr_auto) latched_q <= 1'b0;
        end
    end

    assign latched_o = latched_q;
    assign preset_o  = preset_q;

    // R8
    preset_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset_q |-> (!latched_q && $past(latched_q)));

    // R8
    preset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset_q |=> !preset_q);

    // R6
    latch_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched_q) |-> $past(state_i == ST_CLOSE));

endmodule

// File: rtl/sdlc_rts_ctl.sv
module sdlc_rts_ctl
    import sdlc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_rts_i,
    input  logic       sdlc_i,
    input  logic       fou_i,
    input  logic       rts_bit_i,
    input  logic       unit_end_i,
    input  seq_state_t state_i,
    output logic       rts_o
);

    logic rts_q, armed, hold, close_end;

    assign armed     = auto_rts_i && sdlc_i && fou_i;
    assign close_end = (state_i == ST_CLOSE) && unit_end_i;
    assign hold      = armed && rts_q && in_frame(state_i) && !close_end;

    always_ff @(posedge clk) begin
        if (!rst_n) rts_q <= 1'b0;
        else        rts_q <= rts_bit_i || hold;
    end

    assign rts_o = rts_q;

    // R9
    rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rts_bit_i |=> rts_q);

    // R10
    rts_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_bit_i && !in_frame(state_i)) |=> !rts_q);

endmodule

// File: rtl/sdlc_tx_seq.sv
module sdlc_tx_seq
    import sdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_auto_flag,
    input  logic             cfg_auto_eom,
    input  logic             cfg_auto_rts,
    input  logic             cfg_force_mark,
    input  logic             cfg_idle_flags,
    input  logic             cfg_sdlc,
    input  logic             cfg_flag_on_urun,
    input  logic             tx_en,
    input  logic             rts_bit,
    input  logic             eom_clr,
    input  logic             buf_wr,
    input  logic             bit_tick,
    input  logic             sh_last,
    output logic [CMD_W-1:0] sh_cmd,
    output logic             crc_preset,
    output logic             txd_high,
    output logic             rts_pin,
    output logic             eom_latched
);

    seq_state_t state;
    logic       buf_full;
    logic       unit_end;

    assign unit_end = bit_tick && sh_last;

    sdlc_tx_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .force_i       (cfg_force_mark),
        .tx_en_i       (tx_en),
        .auto_flag_i   (cfg_auto_flag),
        .auto_eom_i    (cfg_auto_eom),
        .idle_flags_i  (cfg_idle_flags),
        .buf_wr_i      (buf_wr),
        .unit_end_i    (unit_end),
        .eom_latched_i (eom_latched),
        .state_o       (state),
        .buf_full_o    (buf_full)
    );

    sdlc_eom_ctl #(.LATCH_RESET(1'b1)) u_eom (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_i    (cfg_force_mark),
        .tx_en_i    (tx_en),
        .auto_eom_i (cfg_auto_eom),
        .clr_cmd_i  (eom_clr),
        .unit_end_i (unit_end),
        .buf_full_i (buf_full),
        .state_i    (state),
        .latched_o  (eom_latched),
        .preset_o   (crc_preset)
    );

    sdlc_rts_ctl u_rts (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_rts_i (cfg_auto_rts),
        .sdlc_i     (cfg_sdlc),
        .fou_i      (cfg_flag_on_urun),
        .rts_bit_i  (rts_bit),
        .unit_end_i (unit_end),
        .state_i    (state),
        .rts_o      (rts_pin)
    );

    always_comb begin
        sh_cmd   = cmd_of(state);
        txd_high = (state == ST_MARK);
    end

    // R11
    mark_cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txd_high |-> (sh_cmd == CMD_IDLE));

endmodule

// File: tb/sdlc_tx_seq_bench.sv
module sdlc_tx_seq_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_auto_flag = 0, cfg_auto_eom = 0, cfg_auto_rts = 0, cfg_force_mark = 0;
    logic cfg_idle_flags = 0, cfg_sdlc = 0, cfg_flag_on_urun = 0;
    logic tx_en = 0, rts_bit = 0, eom_clr = 0, buf_wr = 0;
    logic bit_tick = 0, sh_last = 0;
    logic [1:0] sh_cmd;
    logic crc_preset, txd_high, rts_pin, eom_latched;

    int checks = 0;
    int errors = 0;
    int data_ticks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sdlc_tx_seq u_sdlc_tx_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_auto_flag(cfg_auto_flag), .cfg_auto_eom(cfg_auto_eom),
        .cfg_auto_rts(cfg_auto_rts), .cfg_force_mark(cfg_force_mark),
        .cfg_idle_flags(cfg_idle_flags), .cfg_sdlc(cfg_sdlc),
        .cfg_flag_on_urun(cfg_flag_on_urun), .tx_en(tx_en), .rts_bit(rts_bit),
        .eom_clr(eom_clr), .buf_wr(buf_wr), .bit_tick(bit_tick), .sh_last(sh_last),
        .sh_cmd(sh_cmd), .crc_preset(crc_preset), .txd_high(txd_high),
        .rts_pin(rts_pin), .eom_latched(eom_latched)
    );

    // Behavioural reference: 0 idle, 1 open, 2 data, 3 crc, 4 close, 5 forced
    int m_st = 0;
    int m_buf = 0, m_lat = 1, m_rts = 0, m_pre = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_buf = 0; m_lat = 1; m_rts = 0; m_pre = 0;
        end else begin
            automatic int ue    = (bit_tick && sh_last) ? 1 : 0;
            automatic int ost   = m_st;
            automatic int obuf  = m_buf;
            automatic int olat  = m_lat;
            automatic int orts  = m_rts;
            automatic int go    = (obuf != 0 && tx_en && olat == 0 && (cfg_auto_flag || cfg_idle_flags)) ? 1 : 0;
            automatic int eat   = (ue != 0 && obuf != 0 && (ost == 1 || ost == 2)) ? 1 : 0;
            automatic int take  = (buf_wr && !cfg_force_mark && (tx_en || cfg_auto_flag || cfg_auto_eom)) ? 1 : 0;
            automatic int clr_h = (eom_clr && olat != 0 && ost == 0 && !cfg_force_mark) ? 1 : 0;
            automatic int clr_a = (cfg_auto_eom && olat != 0 && ost == 0 && obuf != 0 && tx_en && !cfg_force_mark) ? 1 : 0;
            automatic int armed = (cfg_auto_rts && cfg_sdlc && cfg_flag_on_urun) ? 1 : 0;
            automatic int infr  = (ost >= 1 && ost <= 4) ? 1 : 0;
            if (cfg_force_mark) m_st = 5;
            else if (ost == 0 && go != 0) m_st = 1;
            else if (ost == 1 && ue != 0) m_st = 2;
            else if (ost == 2 && ue != 0 && obuf == 0) m_st = 3;
            else if (ost == 3 && ue != 0) m_st = 4;
            else if (ost == 4 && ue != 0) m_st = 0;
            else if (ost == 5) m_st = 0;
            m_buf = cfg_force_mark ? 0 : (((obuf != 0 && eat == 0) || take != 0) ? 1 : 0);
            if (ost == 4 && ue != 0 && !cfg_force_mark) m_lat = 1;
            else if (clr_h != 0 || clr_a != 0) m_lat = 0;
            m_pre = (clr_h != 0 || clr_a != 0) ? 1 : 0;
            m_rts = (rts_bit || (armed != 0 && orts != 0 && infr != 0 && !(ost == 4 && ue != 0))) ? 1 : 0;
        end
    end

    function automatic int model_cmd(input int s);
        if (s == 1 || s == 4) return 1;
        if (s == 2) return 2;
        if (s == 3) return 3;
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
        end
    endtask

    // Per-cycle comparison against the reference, half a period after each edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2 sh_cmd", int'(sh_cmd), model_cmd(m_st));
            check("R8 crc_preset", int'(crc_preset), m_pre);
            check("R11 txd_high", int'(txd_high), (m_st == 5) ? 1 : 0);
            check("R6 eom_latched", int'(eom_latched), m_lat);
            if (cfg_auto_rts && cfg_sdlc && cfg_flag_on_urun)
                check("R10 rts_pin", int'(rts_pin), m_rts);
            else
                check("R9 rts_pin", int'(rts_pin), m_rts);
        end
    end

    // Shifter stand-in: eight bits per unit, one bit per tick every four clocks
    int tcnt = 0, bidx = 0, prev_cmd = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            bit_tick = 0; sh_last = 0; tcnt = 0; bidx = 0; prev_cmd = 0;
        end else begin
            if (bit_tick) begin
                if (prev_cmd == 0 || sh_last) bidx = 0;
                else bidx = bidx + 1;
                if (prev_cmd == 2) data_ticks = data_ticks + 1;
            end
            if (sh_cmd == 2'd0) bidx = 0;
            tcnt = tcnt + 1;
            bit_tick = ((tcnt % 4) == 0);
            sh_last = (sh_cmd != 2'd0) && (bidx == 7);
            prev_cmd = int'(sh_cmd);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_wr();
        @(negedge clk); buf_wr = 1;
        @(negedge clk); buf_wr = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); eom_clr = 1;
        @(negedge clk); eom_clr = 0;
    endtask

    task automatic wait_cmd(input int v, input string req);
        int n = 0;
        while (int'(sh_cmd) != v && n < 2000) begin
            @(negedge clk); n++;
        end
        check(req, int'(sh_cmd), v);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int base;
        step(4);
        @(negedge clk); rst_n = 1;
        // R1 reset values
        check("R1 sh_cmd", int'(sh_cmd), 0);
        check("R1 crc_preset", int'(crc_preset), 0);
        check("R1 txd_high", int'(txd_high), 0);
        check("R1 rts_pin", int'(rts_pin), 0);
        check("R1 eom_latched", int'(eom_latched), 1);

        // R9 plain RTS follow
        @(negedge clk); rts_bit = 1; step(3);
        check("R9 rts high", int'(rts_pin), 1);
        rts_bit = 0; step(3);
        check("R9 rts low", int'(rts_pin), 0);

        // R4 write lost when disabled and no auto mode
        pulse_wr();
        tx_en = 1; cfg_idle_flags = 1;
        pulse_clr();
        step(40);
        check("R4 lost write", int'(sh_cmd), 0);
        check("R6 latch cleared by command", int'(eom_latched), 0);

        // R5 single byte frame then underrun to CRC
        base = data_ticks;
        pulse_wr();
        wait_cmd(1, "R2 open flag");
        wait_cmd(2, "R2 data");
        wait_cmd(3, "R5 crc after underrun");
        wait_cmd(0, "R2 back to idle");
        check("R5 one byte", data_ticks - base, 8);
        step(2);
        check("R6 latch set", int'(eom_latched), 1);

        // R6 latch blocks a new frame until the clear command
        pulse_wr();
        step(40);
        check("R6 blocked", int'(sh_cmd), 0);
        base = data_ticks;
        pulse_clr();
        wait_cmd(1, "R6 start after clear");
        wait_cmd(2, "R2 data");
        pulse_wr();
        wait_cmd(3, "R5 crc after chain");
        wait_cmd(0, "R2 idle");
        check("R5 two bytes", data_ticks - base, 16);

        // R7 auto EOM reset, write before enable
        step(4);
        tx_en = 0; cfg_auto_eom = 1;
        pulse_wr();
        step(10);
        tx_en = 1;
        wait_cmd(1, "R7 auto start");
        check("R7 latch auto cleared", int'(eom_latched), 0);
        wait_cmd(0, "R2 idle");

        // R3 mark idle without auto flag never starts
        step(4);
        cfg_idle_flags = 0;
        pulse_wr();
        step(40);
        check("R3 mark idle holds", int'(sh_cmd), 0);
        cfg_auto_flag = 1;
        wait_cmd(1, "R3 auto flag starts");
        wait_cmd(0, "R2 idle");

        // R10 automatic RTS release at end of closing flag
        step(4);
        cfg_auto_rts = 1; cfg_sdlc = 1; cfg_flag_on_urun = 1; rts_bit = 1;
        pulse_wr();
        wait_cmd(2, "R2 data");
        rts_bit = 0;
        wait_cmd(3, "R2 crc");
        check("R10 rts held", int'(rts_pin), 1);
        wait_cmd(0, "R2 idle");
        step(1);
        check("R10 rts released", int'(rts_pin), 0);

        // R11 force mark mid byte
        step(4);
        pulse_wr();
        wait_cmd(2, "R2 data");
        step(3);
        cfg_force_mark = 1; tx_en = 0;
        step(2);
        check("R11 txd high", int'(txd_high), 1);
        check("R11 cmd idle", int'(sh_cmd), 0);
        pulse_wr();
        step(5);
        cfg_force_mark = 0; tx_en = 1;
        step(40);
        check("R11 write lost", int'(sh_cmd), 0);
        check("R11 released", int'(txd_high), 0);

        step(4);
        summary();
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

endmodule